// File: doc/BRIEF.md
# Master Clock Rate Gate and Frame Synchronizer

This block turns an incoming master clock into a timing base of 256 internal ticks per sample period and keeps that base locked to the word clock. A rate select input states whether the master clock runs at 256 or 384 times the sample rate. At 256 times, every master clock cycle carries a tick. At 384 times, a rate gate passes two of every three cycles, so the tick stream still holds 256 ticks per sample period. The ticks are delivered as a clock enable and not as a derived clock.

An active-low power input holds the whole block in reset. Once it is released, the timing stays idle until the first rising edge of the word clock. From then on an 8-bit phase count advances on every tick. The block gives downstream filter stages a frame-start strobe at phase 0 and an eight-times-rate strobe every 32 ticks. On every later word-clock rising edge a phase detector checks that the edge arrives just where the count would have wrapped. If it does not, the count and the rate gate restart from that edge, a one-cycle realign flag is raised, and operation carries on without any reset. Only a frequency lock between the master clock and the word clock is needed; their phase can be anything. The word clock is synchronized into the master clock domain.

Top module: `mclk_frame_sync`

## Requirements
- R1: While `pwr_up_i` is low, all outputs are held at 0, including `phase_o`, whatever the other inputs do.
- R2: After reset is released, no tick or strobe appears until a word-clock rising edge has been seen. That edge raises `tick_o`, `frame_o` and `oct_o` with `phase_o`=0 and `realign_o`=0, on the third rising master clock edge after `wclk_i` goes high (two synchronizer stages and one registered output).
- R3: With `rate_sel_i`=0 (256fs master clock), `tick_o` is high on every cycle once timing has started. `phase_o` rises by one per tick and wraps from 255 to 0.
- R4: With `rate_sel_i`=1 (384fs master clock), ticks follow a fixed pattern of tick, tick, gap that starts at each word-clock edge. Any 384 consecutive cycles without a realign carry exactly 256 ticks.
- R5: `frame_o` is high together with `tick_o` exactly on the ticks where `phase_o` is 0. `oct_o` is high together with `tick_o` on the ticks where `phase_o` is a multiple of 32, which gives 8 per frame.
- R6: When word-clock edges arrive on the tick that would wrap the count from 255 to 0 (256 cycles apart at rate 0, 384 cycles apart at rate 1), `realign_o` stays 0 and the frames keep running without interruption.
- R7: A word-clock edge that arrives anywhere else raises `realign_o` for exactly one cycle, in the same cycle as `frame_o`. `phase_o` restarts at 0 and the tick, tick, gap pattern restarts at that edge.
- R8: If word-clock edges stop, timing keeps running freely: the count keeps wrapping, frame strobes continue, and no realign is flagged.
- R9: A power-down while running returns the block to the R1 state. After release it waits for a new word-clock edge exactly as R2 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 256fs or 384fs |
| pwr_up_i | input | 1 | Active-low power-down: low holds the block in reset |
| rate_sel_i | input | 1 | 0: master clock is 256fs; 1: master clock is 384fs |
| wclk_i | input | 1 | Word clock at the sample rate, frequency-locked to clk_i |
| tick_o | output | 1 | Internal 256fs tick enable |
| frame_o | output | 1 | Frame-start strobe, high on the tick with phase 0 |
| oct_o | output | 1 | Eight-times-rate strobe, high every 32 ticks |
| realign_o | output | 1 | One-cycle flag raised when a word-clock edge forced a phase restart |
| phase_o | output | 8 | Current internal tick index within the frame |

## Verification
A word-clock edge can land on the very tick where the free-running count wraps to 0. The frame start and the phase check then fall in the same cycle, and only the flag separates a clean lock from a realign. The bench shortens and stretches word-clock periods by a few cycles around the nominal 256 or 384. It also switches the rate select between frames, which makes an edge arrive one tick early, one tick late, or on a gap slot of the 384 pattern. Each cycle is judged against a bench model that counts ticks and frames from the requirements. A realign flag must appear on exactly the off-phase edges, and the frame strobe with phase 0 must appear on every edge whether it is aligned or not.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

    typedef enum logic {
        RATE_256 = 1'b0,
        RATE_384 = 1'b1
    } rate_e;

    localparam int unsigned DEF_TICKS    = 256;
    localparam int unsigned DEF_STROBES  = 8;
    localparam int unsigned DEF_SYNC     = 2;
    localparam int unsigned DEF_GATE_NUM = 2;
    localparam int unsigned DEF_GATE_DEN = 3;

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mfs_edge_det.sv
module mfs_edge_det #(
    parameter int unsigned STAGES = mfs_pkg::DEF_SYNC
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic wclk_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } state_t;

    state_t state_q, state_d;

    always_comb begin
        state_d         = state_q;
        state_d.sync[0] = wclk_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            state_d.sync[i] = state_q.sync[i-1];
        end
        state_d.prev    = state_q.sync[STAGES-1];
    end

    assign rise_o = state_q.sync[STAGES-1] & ~state_q.prev;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/mfs_rate_gate.sv
module mfs_rate_gate #(
    parameter int unsigned NUM = mfs_pkg::DEF_GATE_NUM,
    parameter int unsigned DEN = mfs_pkg::DEF_GATE_DEN
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic gate_i,
    input  logic restart_i,
    output logic due_o,
    output logic tick_o
);

    localparam int unsigned SW   = mfs_pkg::width_of(DEN);
    localparam logic [SW-1:0] LAST = SW'(DEN - 1);
    localparam logic [SW-1:0] PASS = SW'(NUM);

    typedef struct packed {
        logic [SW-1:0] slot;
    } state_t;

    state_t        state_q, state_d;
    logic [SW-1:0] slot_adv;
    logic [SW-1:0] slot_now;

    generate
        if (DEN > 1) begin : g_cycle
            assign slot_adv = (state_q.slot == LAST) ? '0 : state_q.slot + SW'(1);
        end else begin : g_flat
            assign slot_adv = '0;
        end
    endgenerate

    always_comb begin
        state_d      = state_q;
        slot_now     = restart_i ? '0 : slot_adv;
        state_d.slot = slot_now;
    end

    // due: tick the cycle would carry with no restart; tick: what it does carry
    assign due_o  = !gate_i || (slot_adv < PASS);
    assign tick_o = !gate_i || (slot_now < PASS);

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/mfs_frame_ctr.sv
module mfs_frame_ctr #(
    parameter int unsigned TICKS   = mfs_pkg::DEF_TICKS,
    parameter int unsigned STROBES = mfs_pkg::DEF_STROBES
) (
    input  logic                                  clk_i,
    input  logic                                  rst_n_i,
    input  logic                                  rise_i,
    input  logic                                  due_i,
    input  logic                                  tick_i,
    output logic                                  tick_o,
    output logic                                  frame_o,
    output logic                                  oct_o,
    output logic                                  realign_o,
    output logic [mfs_pkg::width_of(TICKS)-1:0]   phase_o
);

    localparam int unsigned CW   = mfs_pkg::width_of(TICKS);
    localparam int unsigned STEP = TICKS / STROBES;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] phase;
        logic          tick;
        logic          frame;
        logic          oct;
        logic          realign;
    } state_t;

    state_t state_q, state_d;

    always_comb begin
        state_d         = state_q;
        state_d.tick    = 1'b0;
        state_d.frame   = 1'b0;
        state_d.oct     = 1'b0;
        state_d.realign = 1'b0;
        if (rise_i) begin
            // in phase only if this edge lands on the tick that wraps the count
            state_d.realign = state_q.run && !(due_i && (state_q.phase == LAST));
            state_d.run     = 1'b1;
            state_d.phase   = '0;
            state_d.tick    = 1'b1;
            state_d.frame   = 1'b1;
            state_d.oct     = 1'b1;
        end else if (state_q.run && tick_i) begin
            state_d.phase = (state_q.phase == LAST) ? '0 : state_q.phase + CW'(1);
            state_d.tick  = 1'b1;
            state_d.frame = (state_d.phase == '0);
            state_d.oct   = ((32'(state_d.phase) % STEP) == 0);
        end
    end

    assign tick_o    = state_q.tick;
    assign frame_o   = state_q.frame;
    assign oct_o     = state_q.oct;
    assign realign_o = state_q.realign;
    assign phase_o   = state_q.phase;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/mclk_frame_sync.sv
module mclk_frame_sync #(
    parameter int unsigned TICKS_PER_FRAME   = mfs_pkg::DEF_TICKS,
    parameter int unsigned STROBES_PER_FRAME = mfs_pkg::DEF_STROBES,
    parameter int unsigned SYNC_STAGES       = mfs_pkg::DEF_SYNC,
    parameter int unsigned GATE_NUM          = mfs_pkg::DEF_GATE_NUM,
    parameter int unsigned GATE_DEN          = mfs_pkg::DEF_GATE_DEN
) (
    input  logic                                           clk_i,
    input  logic                                           pwr_up_i,
    input  logic                                           rate_sel_i,
    input  logic                                           wclk_i,
    output logic                                           tick_o,
    output logic                                           frame_o,
    output logic                                           oct_o,
    output logic                                           realign_o,
    output logic [mfs_pkg::width_of(TICKS_PER_FRAME)-1:0]  phase_o
);

    localparam int unsigned CNT_W = mfs_pkg::width_of(TICKS_PER_FRAME);
    localparam int unsigned STEP  = TICKS_PER_FRAME / STROBES_PER_FRAME;

    logic rst_n;
    logic gate_on;
    logic rise;
    logic due;
    logic tick_en;

    assign rst_n   = pwr_up_i;
    assign gate_on = (mfs_pkg::rate_e'(rate_sel_i) == mfs_pkg::RATE_384);

    mfs_edge_det #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk_i   (clk_i),
        .rst_n_i (rst_n),
        .wclk_i  (wclk_i),
        .rise_o  (rise)
    );

    mfs_rate_gate #(
        .NUM (GATE_NUM),
        .DEN (GATE_DEN)
    ) u_gate (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n),
        .gate_i    (gate_on),
        .restart_i (rise),
        .due_o     (due),
        .tick_o    (tick_en)
    );

    mfs_frame_ctr #(
        .TICKS   (TICKS_PER_FRAME),
        .STROBES (STROBES_PER_FRAME)
    ) u_frame (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n),
        .rise_i    (rise),
        .due_i     (due),
        .tick_i    (tick_en),
        .tick_o    (tick_o),
        .frame_o   (frame_o),
        .oct_o     (oct_o),
        .realign_o (realign_o),
        .phase_o   (phase_o)
    );

endmodule

// File: rtl/mfs_checker.sv
module mfs_checker #(
    parameter int unsigned CW   = 8,
    parameter int unsigned STEP = 32
) (
    input logic          clk_i,
    input logic          pwr_up_i,
    input logic          rate_sel_i,
    input logic          tick_o,
    input logic          frame_o,
    input logic          oct_o,
    input logic          realign_o,
    input logic [CW-1:0] phase_o
);

    always @(posedge clk_i) begin
        if (!pwr_up_i) begin
            p_quiet_in_reset_r1: assert (!tick_o && !frame_o && !oct_o && !realign_o && phase_o == '0)
                else $error("outputs active while powered down");
        end
    end

    p_phase_step_r3: assert property (@(posedge clk_i) disable iff (!pwr_up_i)
        (tick_o && !frame_o) |-> (phase_o == $past(phase_o) + CW'(1)));

    p_full_rate_r3: assert property (@(posedge clk_i) disable iff (!pwr_up_i)
        (tick_o && !rate_sel_i) |=> tick_o);

    p_gap_closes_r4: assert property (@(posedge clk_i) disable iff (!pwr_up_i)
        (rate_sel_i && $past(rate_sel_i) && !tick_o && $past(tick_o)) |=> tick_o);

    p_frame_at_zero_r5: assert property (@(posedge clk_i) disable iff (!pwr_up_i)
        frame_o |-> (tick_o && phase_o == '0));

    p_oct_grid_r5: assert property (@(posedge clk_i) disable iff (!pwr_up_i)
        oct_o |-> (tick_o && (32'(phase_o) % STEP) == 0));

    p_realign_framed_r7: assert property (@(posedge clk_i) disable iff (!pwr_up_i)
        realign_o |-> frame_o);

    p_realign_single_r7: assert property (@(posedge clk_i) disable iff (!pwr_up_i)
        realign_o |=> !realign_o);

endmodule

bind mclk_frame_sync mfs_checker #(
    .CW   (CNT_W),
    .STEP (STEP)
) u_chk (
    .clk_i      (clk_i),
    .pwr_up_i   (pwr_up_i),
    .rate_sel_i (rate_sel_i),
    .tick_o     (tick_o),
    .frame_o    (frame_o),
    .oct_o      (oct_o),
    .realign_o  (realign_o),
    .phase_o    (phase_o)
);

// File: tb/mclk_frame_sync_tb_top.sv
module mclk_frame_sync_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       pwr_b = 1'b0;
    logic       sel_b = 1'b0;
    logic       wclk_b = 1'b0;
    logic       tick_o, frame_o, oct_o, realign_o;
    logic [7:0] phase_o;

    mclk_frame_sync dut_i (
        .clk_i      (clk),
        .pwr_up_i   (pwr_b),
        .rate_sel_i (sel_b),
        .wclk_i     (wclk_b),
        .tick_o     (tick_o),
        .frame_o    (frame_o),
        .oct_o      (oct_o),
        .realign_o  (realign_o),
        .phase_o    (phase_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model built from the requirements
    logic [1:0] m_sync = '0;
    logic       m_prev = 1'b0;
    int         m_slot = 0;
    bit         m_run = 1'b0;
    int         m_phase = 0;
    bit         e_tick = 0, e_frame = 0, e_oct = 0, e_realign = 0;

    int  vecs = 0, fails = 0, cycles = 0;
    int  d_ticks = 0, d_frames = 0, d_octs = 0, d_realigns = 0, m_frames = 0;
    bit  done = 0;
    string seg_tag = "R1";

    function automatic int adv_slot(input int s);
        return (s == 2) ? 0 : s + 1;
    endfunction

    task automatic model_zero();
        m_sync = '0; m_prev = 0; m_slot = 0; m_run = 0; m_phase = 0;
        e_tick = 0; e_frame = 0; e_oct = 0; e_realign = 0;
    endtask

    always @(posedge clk) begin
        if (pwr_b) begin
            bit rise_m, due_m;
            int ns;
            rise_m = m_sync[1] & ~m_prev;
            m_prev = m_sync[1];
            m_sync = {m_sync[0], wclk_b};
            ns     = adv_slot(m_slot);
            due_m  = !sel_b || (ns < 2);
            e_realign = 0;
            if (rise_m) begin
                e_realign = m_run && !(due_m && m_phase == 255);
                m_run = 1; m_phase = 0; m_slot = 0;
                e_tick = 1; e_frame = 1; e_oct = 1;
            end else begin
                m_slot = ns;
                if (m_run && due_m) begin
                    m_phase = (m_phase + 1) % 256;
                    e_tick = 1; e_frame = (m_phase == 0); e_oct = (m_phase % 32 == 0);
                end else begin
                    e_tick = 0; e_frame = 0; e_oct = 0;
                end
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected below %0d", cycles, WATCHDOG);
            summary();
        end
    end

    task automatic check_vec();
        vecs++;
        if ({tick_o, frame_o, oct_o, realign_o} !== {e_tick, e_frame, e_oct, e_realign} ||
            phase_o !== 8'(m_phase)) begin
            fails++;
            $display("FAIL %s: tick/frame/oct/realign=%b%b%b%b phase=%0d expected %b%b%b%b phase=%0d",
                     seg_tag, tick_o, frame_o, oct_o, realign_o, phase_o,
                     e_tick, e_frame, e_oct, e_realign, m_phase);
        end
        d_ticks    += int'(tick_o);
        d_frames   += int'(frame_o);
        d_octs     += int'(oct_o);
        d_realigns += int'(realign_o);
        m_frames   += int'(e_frame);
    endtask

    task automatic expect_int(input string tag, input string what, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_counts();
        d_ticks = 0; d_frames = 0; d_octs = 0; d_realigns = 0; m_frames = 0;
    endtask

    task automatic cyc(input logic w, input logic s, input logic p);
        @(negedge clk);
        check_vec();
        wclk_b = w; sel_b = s; pwr_b = p;
        if (!p) model_zero();
    endtask

    task automatic frame(input int len, input logic s);
        for (int i = 0; i < len; i++) cyc(i < len / 2, s, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd1357));
        // R1: held in reset with a toggling word clock
        seg_tag = "R1";
        for (int i = 0; i < 8; i++) cyc(1'($urandom), 1'($urandom), 1'b0);
        // R2: released but no word clock edge yet
        seg_tag = "R2";
        clear_counts();
        for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0, 1'b1);
        expect_int("R2", "ticks before first edge", d_ticks, 0);
        // R3/R5/R6: locked at 256fs
        seg_tag = "R3";
        frame(256, 1'b0);
        clear_counts();
        for (int k = 0; k < 4; k++) frame(256, 1'b0);
        expect_int("R6", "realigns while locked", d_realigns, 0);
        expect_int("R5", "frame strobes in 4 frames", d_frames, 4);
        expect_int("R5", "oct strobes in 4 frames", d_octs, 32);
        expect_int("R3", "ticks in 4 frames", d_ticks, 1024);
        // R7: early and late edges
        seg_tag = "R7";
        clear_counts();
        frame(250, 1'b0); frame(263, 1'b0); frame(256, 1'b0); frame(256, 1'b0);
        expect_int("R7", "realigns for early+late edge", d_realigns, 2);
        // R4: locked at 384fs
        seg_tag = "R4";
        frame(384, 1'b1);
        clear_counts();
        for (int k = 0; k < 3; k++) frame(384, 1'b1);
        expect_int("R4", "ticks in 3x384 cycles", d_ticks, 768);
        expect_int("R4", "frames in 3x384 cycles", d_frames, 3);
        expect_int("R6", "realigns locked at 384fs", d_realigns, 0);
        // R7: random periods and rate switches
        seg_tag = "R7";
        for (int k = 0; k < 14; k++) begin
            logic s;
            int   len;
            s   = 1'($urandom);
            len = (s ? 384 : 256) + int'($urandom % 7) - 3;
            frame(len, s);
        end
        // R8: word clock stops, timing free-runs
        seg_tag = "R8";
        frame(256, 1'b0); frame(256, 1'b0);
        clear_counts();
        for (int i = 0; i < 700; i++) cyc(1'b0, 1'b0, 1'b1);
        expect_int("R8", "realigns while free-running", d_realigns, 0);
        expect_int("R8", "frames while free-running", d_frames, m_frames);
        expect_int("R8", "at least two frames free-running", int'(d_frames >= 2), 1);
        // R9: power-down mid run, then restart
        seg_tag = "R9";
        frame(300, 1'b1);
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b0);
        clear_counts();
        for (int i = 0; i < 40; i++) cyc(1'b0, 1'b1, 1'b1);
        expect_int("R9", "ticks after power-down before edge", d_ticks, 0);
        frame(384, 1'b1); frame(384, 1'b1);
        clear_counts();
        frame(384, 1'b1);
        expect_int("R9", "realigns after restart", d_realigns, 0);
        cyc(1'b0, 1'b1, 1'b1);
        summary();
    end

endmodule